// File: doc/BRIEF.md
# Single-Wire Command Slave

This block is the slave end of a half-duplex serial link that runs over one open-drain wire. The pin is seen as a sampled input, `pin_i`, and an output enable, `pin_oe`, that pulls the wire low when it is high. Every bit cell begins when the sender pulls the wire low. The level on the wire a fixed time after that falling edge carries the bit: a 1 is a short low pulse, and a 0 is a long one.

A transfer opens with an 8-bit command from the host. The command holds a 7-bit register code and a direction flag. For a store command, the host then sends a 16-bit word and the block presents it on a register port with a one-cycle write strobe. For a fetch command, the block waits a response delay, samples the register port's read data, and sends that word back in bit cells of its own.

A host that stalls partway through a transfer triggers a gap timeout, which drops the partial transfer. A host can also hold the wire low for the break time, which brings the interface back to waiting for a command at any point. Every timing limit is a parameter counted in system-clock cycles.

Top module: `owire_cmd_slave`

## Requirements
- R1: Command layout. Bit 7 of the command is the direction: 1 means store and 0 means fetch. Bits 6 to 0 are the register code, which appears on `reg_addr`.
- R2: Both the command and the 16-bit word travel least significant bit first, in both directions.
- R3: The receiver samples the wire SMP_OFS cycles after each falling edge it detects. A high level decodes as 1 and a low level decodes as 0.
- R4: After a store command, the 16th received data bit causes `reg_wr` to be high for exactly one cycle. In that cycle `reg_addr` holds the command's code and `reg_wdata` holds the received word.
- R5: After a fetch command, the block waits at least RSP_DLY cycles after sampling the last command bit. It then sends `reg_rdata` for the addressed register as 16 bits.
- R6: In each transmitted bit cell, `pin_oe` is high for exactly TX_LOW1 cycles for a 1 or TX_LOW0 cycles for a 0. Successive cells start TX_CELL+1 cycles apart.
- R7: `pin_oe` is high only while a fetch response is being sent. It is never high while the block is receiving.
- R8: During a partial command or a store word, if no falling edge arrives within TMO_CYC cycles of the previous one, the partial transfer is discarded with no write. The block then accepts a new command.
- R9: A low level that lasts BRK_CYC cycles is a break. A break discards any partial transfer and returns the block to waiting for a command.
- R10: After reset, `pin_oe` and `reg_wr` are low and the block waits for a command.
- R11: Transfers can follow one another directly, with a store following a fetch and a fetch following a store, and no idle time is needed beyond the ends of the bit cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Sampled level of the shared wire |
| pin_oe | output | 1 | When high, pulls the wire low |
| reg_addr | output | 7 | Register code from the last command |
| reg_wdata | output | 16 | Word received for a store |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Contents of the register selected by `reg_addr` |

## Verification
The embedded assertions check several rules on every cycle. The wire is driven only in the transmit state, and the write strobe lasts one cycle and only follows the data-receive state. A break returns the controller to an empty command state. A gap timeout during a word ends it without a write. The transmitter accepts a new bit only when it is idle and never holds the wire low longer than the longer of its two pulse widths.

Some behaviours show only at the ports, so the directed scenarios check them. These are the decoded register code and word, the least-significant-bit-first order, and the exact transmit pulse widths and cell spacing. They also cover the response delay, the discarding of stalled or broken transfers, and back-to-back traffic.

// File: rtl/owire_pkg.sv
package owire_pkg;

    typedef enum logic [1:0] {
        ST_CMD,
        ST_WDATA,
        ST_RESP,
        ST_TX
    } ow_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_LOW,
        TX_HIGH
    } tx_state_e;

endpackage

// File: rtl/owire_rx.sv
module owire_rx #(
    parameter int SMP_OFS = 40,
    parameter int BRK_CYC = 400,
    parameter int TMO_CYC = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic bit_stb,
    output logic bit_val,
    output logic brk,
    output logic gap_over
);
    localparam int AGE_W = $clog2(TMO_CYC + 1);
    localparam int LOW_W = $clog2(BRK_CYC + 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic             line;
        logic [AGE_W-1:0] age;
        logic [LOW_W-1:0] low_cnt;
        logic             bit_stb;
        logic             bit_val;
        logic             brk;
    } rx_t;

    rx_t q, d;
    logic fall;

    always_comb begin
        d         = q;
        d.sync    = {q.sync[0], pin_i};
        d.line    = q.sync[1];
        d.bit_stb = 1'b0;
        d.brk     = 1'b0;
        fall      = q.line & ~q.sync[1];

        // cycles since the last falling edge, saturating at the timeout
        if (fall) begin
            d.age = '0;
        end else if (q.age != AGE_W'(TMO_CYC)) begin
            d.age = q.age + 1'b1;
        end

        // one sample per bit cell at a fixed offset
        if (!fall && q.age == AGE_W'(SMP_OFS)) begin
            d.bit_stb = 1'b1;
            d.bit_val = q.line;
        end

        // continuous low time for break detection
        if (q.sync[1]) begin
            d.low_cnt = '0;
        end else if (q.low_cnt != LOW_W'(BRK_CYC)) begin
            d.low_cnt = q.low_cnt + 1'b1;
            if (q.low_cnt == LOW_W'(BRK_CYC - 1)) begin
                d.brk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync    <= 2'b11;
            q.line    <= 1'b1;
            q.age     <= AGE_W'(TMO_CYC);
            q.low_cnt <= '0;
            q.bit_stb <= 1'b0;
            q.bit_val <= 1'b0;
            q.brk     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign bit_stb  = q.bit_stb;
    assign bit_val  = q.bit_val;
    assign brk      = q.brk;
    assign gap_over = (q.age == AGE_W'(TMO_CYC));

    AST_BRK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !brk); // R9

    AST_SAMPLE_NOT_AT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> !gap_over); // R3

endmodule

// File: rtl/owire_tx.sv
module owire_tx
    import owire_pkg::*;
#(
    parameter int TX_LOW1 = 10,
    parameter int TX_LOW0 = 70,
    parameter int TX_CELL = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic go_bit,
    output logic oe,
    output logic done
);
    localparam int CNT_W   = $clog2(TX_CELL + 1);
    localparam int MAX_LOW = (TX_LOW1 > TX_LOW0) ? TX_LOW1 : TX_LOW0;

    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] low_len;
        logic             oe;
        logic             done;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            TX_IDLE: begin
                if (go) begin
                    d.st      = TX_LOW;
                    d.cnt     = '0;
                    d.low_len = go_bit ? CNT_W'(TX_LOW1) : CNT_W'(TX_LOW0);
                end
            end
            TX_LOW: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == q.low_len - 1'b1) begin
                    d.st = TX_HIGH;
                end
            end
            TX_HIGH: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(TX_CELL - 1)) begin
                    d.st   = TX_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = TX_IDLE;
        endcase
        d.oe = (d.st == TX_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= TX_IDLE;
            q.cnt     <= '0;
            q.low_len <= '0;
            q.oe      <= 1'b0;
            q.done    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign oe   = q.oe;
    assign done = q.done;

    AST_TX_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (q.st == TX_IDLE)); // R6

    AST_TX_LOW_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (q.cnt < CNT_W'(MAX_LOW))); // R6

endmodule

// File: rtl/owire_cmd_slave.sv
module owire_cmd_slave
    import owire_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 16,
    parameter int SMP_OFS = 40,
    parameter int BRK_CYC = 400,
    parameter int TMO_CYC = 600,
    parameter int TX_LOW1 = 10,
    parameter int TX_LOW0 = 70,
    parameter int TX_CELL = 100,
    parameter int RSP_DLY = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    output logic              pin_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int CMD_W = ADDR_W + 1;
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int RSP_W = $clog2(RSP_DLY + 1);

    typedef struct packed {
        ow_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shift;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [RSP_W-1:0]  timer;
    } ctl_t;

    ctl_t q, d;

    logic              bit_stb, bit_val, brk, gap_over;
    logic              tx_go, tx_bit, tx_oe, tx_done;
    logic [DATA_W-1:0] shift_in;

    owire_rx #(
        .SMP_OFS (SMP_OFS),
        .BRK_CYC (BRK_CYC),
        .TMO_CYC (TMO_CYC)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .brk      (brk),
        .gap_over (gap_over)
    );

    owire_tx #(
        .TX_LOW1 (TX_LOW1),
        .TX_LOW0 (TX_LOW0),
        .TX_CELL (TX_CELL)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (tx_go),
        .go_bit (tx_bit),
        .oe     (tx_oe),
        .done   (tx_done)
    );

    always_comb begin
        d        = q;
        d.wr     = 1'b0;
        tx_go    = 1'b0;
        tx_bit   = 1'b0;
        shift_in = {bit_val, q.shift[DATA_W-1:1]};

        if (brk) begin
            d.st  = ST_CMD;
            d.cnt = '0;
        end else begin
            case (q.st)
                ST_CMD: begin
                    if (gap_over && q.cnt != '0) begin
                        d.cnt = '0;
                    end else if (bit_stb) begin
                        d.shift = shift_in;
                        if (q.cnt == CNT_W'(CMD_W - 1)) begin
                            d.addr  = shift_in[DATA_W-CMD_W +: ADDR_W];
                            d.cnt   = '0;
                            d.timer = '0;
                            d.st    = bit_val ? ST_WDATA : ST_RESP;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_WDATA: begin
                    if (gap_over) begin
                        d.st  = ST_CMD;
                        d.cnt = '0;
                    end else if (bit_stb) begin
                        d.shift = shift_in;
                        if (q.cnt == CNT_W'(DATA_W - 1)) begin
                            d.wr    = 1'b1;
                            d.wdata = shift_in;
                            d.st    = ST_CMD;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_RESP: begin
                    d.timer = q.timer + 1'b1;
                    if (q.timer == RSP_W'(RSP_DLY - 1)) begin
                        d.st    = ST_TX;
                        d.shift = reg_rdata;
                        d.cnt   = '0;
                        tx_go   = 1'b1;
                        tx_bit  = reg_rdata[0];
                    end
                end
                ST_TX: begin
                    if (tx_done) begin
                        if (q.cnt == CNT_W'(DATA_W - 1)) begin
                            d.st  = ST_CMD;
                            d.cnt = '0;
                        end else begin
                            d.cnt   = q.cnt + 1'b1;
                            d.shift = q.shift >> 1;
                            tx_go   = 1'b1;
                            tx_bit  = q.shift[1];
                        end
                    end
                end
                default: begin
                    d.st  = ST_CMD;
                    d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_CMD;
            q.cnt   <= '0;
            q.shift <= '0;
            q.addr  <= '0;
            q.wr    <= 1'b0;
            q.wdata <= '0;
            q.timer <= '0;
        end else begin
            q <= d;
        end
    end

    assign pin_oe    = tx_oe;
    assign reg_addr  = q.addr;
    assign reg_wdata = q.wdata;
    assign reg_wr    = q.wr;

    AST_OE_ONLY_TX: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> (q.st == ST_TX)); // R7

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R4

    AST_WR_FROM_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> ($past(q.st) == ST_WDATA)); // R4

    AST_BRK_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> (q.st == ST_CMD && q.cnt == '0 && !reg_wr)); // R9

    AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_over && q.st == ST_WDATA && !brk) |=> (q.st == ST_CMD && !reg_wr)); // R8

endmodule

// File: tb/sim_owire_cmd_slave.sv
module sim_owire_cmd_slave;

    localparam int SMP_OFS = 40;
    localparam int TMO_CYC = 600;
    localparam int TX_LOW1 = 10;
    localparam int TX_LOW0 = 70;
    localparam int TX_CELL = 100;
    localparam int RSP_DLY = 150;
    localparam int H_CELL  = 100;
    localparam int H_LOW1  = 10;
    localparam int H_LOW0  = 70;
    localparam int H_BREAK = 450;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_low = 1'b0;
    logic        pin_oe;
    logic [6:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_wr;
    logic [15:0] reg_rdata;
    logic        pin_i;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int wr_cnt = 0;
    int oe_bad = 0;
    int last_fall = 0;
    logic        expect_tx = 1'b0;
    logic        finished = 1'b0;
    logic [6:0]  last_addr = '0;
    logic [15:0] last_data = '0;

    always #10 clk = ~clk;

    assign pin_i     = !(host_low || pin_oe);
    assign reg_rdata = {reg_addr, ~reg_addr, 2'b10};

    owire_cmd_slave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .pin_oe    (pin_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rdata (reg_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (reg_wr) begin
            wr_cnt    <= wr_cnt + 1;
            last_addr <= reg_addr;
            last_data <= reg_wdata;
        end
        if (rst_n && pin_oe && !expect_tx) oe_bad <= oe_bad + 1;
    end

    function automatic logic [15:0] model_rd(input logic [6:0] a);
        return {a, ~a, 2'b10};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_bit(input logic b);
        int low;
        low = b ? H_LOW1 : H_LOW0;
        @(negedge clk);
        host_low  = 1'b1;
        last_fall = cyc;
        repeat (low) @(negedge clk);
        host_low = 1'b0;
        repeat (H_CELL - low - 1) @(negedge clk);
    endtask

    task automatic host_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) host_bit(v[i]);
    endtask

    task automatic host_word(input logic [15:0] v);
        for (int i = 0; i < 16; i++) host_bit(v[i]);
    endtask

    task automatic host_break();
        @(negedge clk);
        host_low = 1'b1;
        repeat (H_BREAK) @(negedge clk);
        host_low = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic wait_oe(input logic lvl, output int t, output logic ok);
        int n;
        n  = 0;
        ok = 1'b1;
        while (pin_oe !== lvl) begin
            @(negedge clk);
            n++;
            if (n > 5000) begin
                ok = 1'b0;
                break;
            end
        end
        t = cyc;
    endtask

    task automatic t_reset();
        check(pin_oe === 1'b0, "R10 pin_oe after reset", int'(pin_oe), 0);
        check(reg_wr === 1'b0, "R10 reg_wr after reset", int'(reg_wr), 0);
    endtask

    // R1 R2 R3 R4: store command followed by a word
    task automatic t_write(input logic [6:0] a, input logic [15:0] v, input string tag);
        int w0;
        w0 = wr_cnt;
        host_byte({1'b1, a});
        host_word(v);
        repeat (5) @(negedge clk);
        check(wr_cnt == w0 + 1, {tag, " R4 single write strobe"}, wr_cnt - w0, 1);
        check(last_addr == a, {tag, " R1 register code"}, int'(last_addr), int'(a));
        check(last_data == v, {tag, " R2 R3 word lsb first"}, int'(last_data), int'(v));
    endtask

    // R5 R6 R7: fetch command and its response
    task automatic t_read(input logic [6:0] a, input string tag);
        int          w0, t_rise, t_fall, t_prev, dly, low, bad_low, bad_per;
        logic        ok;
        logic [15:0] got, exp;
        w0        = wr_cnt;
        exp       = model_rd(a);
        bad_low   = 0;
        bad_per   = 0;
        got       = '0;
        t_prev    = 0;
        host_byte({1'b0, a});
        expect_tx = 1'b1;
        wait_oe(1'b1, t_rise, ok);
        dly = t_rise - last_fall;
        check(ok && dly >= RSP_DLY && dly <= RSP_DLY + SMP_OFS + 20,
              {tag, " R5 response delay"}, dly, RSP_DLY);
        for (int i = 0; i < 16; i++) begin
            if (i > 0) begin
                wait_oe(1'b1, t_rise, ok);
                if (t_rise - t_prev != TX_CELL + 1) bad_per++;
            end
            t_prev = t_rise;
            wait_oe(1'b0, t_fall, ok);
            low    = t_fall - t_rise;
            got[i] = (low < SMP_OFS);
            if (low != (exp[i] ? TX_LOW1 : TX_LOW0)) bad_low++;
        end
        repeat (TX_CELL + 5) @(negedge clk);
        expect_tx = 1'b0;
        check(got == exp, {tag, " R5 R2 returned word"}, int'(got), int'(exp));
        check(bad_low == 0, {tag, " R6 pulse widths"}, bad_low, 0);
        check(bad_per == 0, {tag, " R6 cell spacing"}, bad_per, 0);
        check(wr_cnt == w0, {tag, " R5 no write on fetch"}, wr_cnt - w0, 0);
        check(pin_oe === 1'b0, {tag, " R7 released after response"}, int'(pin_oe), 0);
    endtask

    // R8: stall partway through a word, then a fresh store
    task automatic t_timeout_data();
        int w0;
        w0 = wr_cnt;
        host_byte({1'b1, 7'h11});
        for (int i = 0; i < 5; i++) host_bit(1'b0);
        repeat (TMO_CYC + 100) @(negedge clk);
        check(wr_cnt == w0, "R8 stalled word dropped", wr_cnt - w0, 0);
        t_write(7'h22, 16'h1234, "R8 after data stall");
    endtask

    // R8: stall partway through a command
    task automatic t_timeout_cmd();
        host_bit(1'b1);
        host_bit(1'b1);
        host_bit(1'b0);
        repeat (TMO_CYC + 100) @(negedge clk);
        t_write(7'h05, 16'hBEEF, "R8 after command stall");
    endtask

    // R9: break in the middle of a word and of a command
    task automatic t_break();
        int w0;
        w0 = wr_cnt;
        host_byte({1'b1, 7'h33});
        for (int i = 0; i < 8; i++) host_bit(1'b1);
        host_break();
        check(wr_cnt == w0, "R9 word dropped by break", wr_cnt - w0, 0);
        t_write(7'h44, 16'h0F0F, "R9 after break in word");
        host_bit(1'b1);
        host_bit(1'b0);
        host_bit(1'b1);
        host_bit(1'b1);
        host_break();
        t_write(7'h6A, 16'hC3A5, "R9 after break in command");
    endtask

    // R11: store, fetch, store without idle gaps
    task automatic t_back_to_back();
        t_write(7'h01, 16'h8001, "R11 first");
        t_read(7'h01, "R11 fetch");
        t_write(7'h7E, 16'h7FFE, "R11 last");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_write(7'h15, 16'hA55A, "W1");
        t_write(7'h7F, 16'h0001, "W2");
        t_write(7'h00, 16'hFFFF, "W3");
        t_read(7'h2C, "RD1");
        t_read(7'h7F, "RD2");
        t_timeout_data();
        t_timeout_cmd();
        t_break();
        t_back_to_back();
        check(oe_bad == 0, "R7 no drive while receiving", oe_bad, 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule